// File: doc/BRIEF.md
# Vector Register Load/Store Unit with Unscaled Offset

This unit executes one load or store between memory and a 128-bit vector register. It takes a 32-bit instruction word and checks that the fixed bits are correct and that the width code is legal. It forms the effective address from a base value plus a signed 9-bit byte offset. It then issues a single memory request of 1, 2, 4, 8 or 16 bytes and waits for the matching response. The base value comes from a general register read port. When the base index is 31, it comes from the stack-pointer input instead, and in that case the stack pointer must be 16-byte aligned.

The instruction handshake is valid/ready: `instr_ready` is high only while the unit is idle, and the word and both read ports are sampled in the cycle of acceptance. The request channel is valid/ready. Once raised, `req_valid` and every request field stay unchanged until the cycle in which `req_ready` is high. The response channel is valid/ready. `rsp_ready` is high only while a response is awaited. A load writes the vector register file one cycle after the response handshake. Every instruction ends with a one-cycle `done` pulse. An illegal word or a misaligned stack pointer ends the instruction early with `done` and a flag raised, and no request is made.

Top module: `vls_unit`

## Requirements
- R1: The width code is a 3-bit value made of word bit 23 (above) and word bits 31:30. It appears on `req_size`. `req_be` has its lowest 2^`req_size` bits set and all other bits clear.
- R2: A width code greater than 4 raises `undef_flag` together with `done` in the cycle after acceptance. It makes no request and no vector register write.
- R3: Any mismatch in the fixed fields raises `undef_flag` exactly as in R2. The fixed fields are bits 29:27 = 111, bit 26 = 1, bits 25:24 = 00, bit 21 = 0 and bits 11:10 = 00.
- R4: `req_addr` equals the base value plus word bits 20:12 sign-extended to 64 bits, taken modulo 2^64.
- R5: Word bit 22 = 1 makes a load (`req_write` = 0). Bit 22 = 0 makes a store (`req_write` = 1).
- R6: A base index (bits 9:5) of 31 uses `sp_value` as the base and drives `req_tagged` low. Any other index uses `gpr_rd_data` (read at `gpr_rd_idx`, which equals bits 9:5) and drives `req_tagged` high.
- R7: With base index 31 and `sp_value[3:0]` not zero, `align_fault` is raised together with `done` in the cycle after acceptance. No request and no write follow.
- R8: A load raises `vreg_wr_en` for one cycle, one cycle after the response handshake. It writes `rsp_rdata` with every byte above 2^scale cleared into register bits 4:0 of the word.
- R9: A store sends `vreg_rd_data` (read at `vreg_rd_idx`, which equals bits 4:0) with every byte above 2^scale cleared.
- R10: `busy` is high from the cycle after acceptance until the response handshake. `instr_ready` is its inverse. `done` pulses one cycle after the response handshake. Request fields hold steady while `req_valid` is high and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, word accepted when valid |
| instr_word | input | 32 | Load/store instruction word |
| gpr_rd_idx | output | 5 | General register read index (word bits 9:5) |
| gpr_rd_data | input | 64 | General register read data, same cycle |
| sp_value | input | 64 | Stack-pointer value |
| vreg_rd_idx | output | 5 | Vector register read index (word bits 4:0) |
| vreg_rd_data | input | 128 | Vector register read data, same cycle |
| vreg_wr_en | output | 1 | Vector register write strobe |
| vreg_wr_idx | output | 5 | Vector register write index |
| vreg_wr_data | output | 128 | Zero-extended load data |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | 64 | Effective byte address |
| req_write | output | 1 | 1 = store, 0 = load |
| req_size | output | 3 | Width code, bytes = 2^req_size |
| req_tagged | output | 1 | Access is tag-checked |
| req_be | output | 16 | Byte enables |
| req_wdata | output | 128 | Store data, upper bytes cleared |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Unit waiting for response |
| rsp_rdata | input | 128 | Load data from memory |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| undef_flag | output | 1 | Illegal word, valid with done |
| align_fault | output | 1 | Misaligned stack pointer, valid with done |

## Verification
The checker assumes that both read ports return their data combinationally in the cycle of acceptance. It also assumes that memory raises `rsp_valid` only after the request handshake, at most once for each request. The bench keeps to these assumptions. It models both register files as pure functions of the index. Its responder raises `req_ready` and `rsp_valid` for exactly one cycle each, after a chosen number of wait cycles, and only in the phase where the unit is waiting for them. Under these conditions, the request-stability and byte-enable properties depend only on the unit's own state.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 9;
  localparam int RIDX_W  = 5;
  localparam int SCALE_W = 3;
  localparam int MAX_SCALE = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_WAIT   = 2'd2
  } vls_state_e;

  typedef struct packed {
    logic               undef;
    logic               is_load;
    logic               use_sp;
    logic [SCALE_W-1:0] scale;
    logic [RIDX_W-1:0]  base_idx;
    logic [RIDX_W-1:0]  xfer_idx;
    logic [IMM_W-1:0]   imm;
  } vls_dec_t;
endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
#(
  parameter int BE_W = 16
) (
  input  logic [INSTR_W-1:0] word_i,
  output vls_dec_t           dec_o,
  output logic [BE_W-1:0]    be_o
);
  localparam int CNT_W = $clog2(BE_W) + 2;

  logic               fixed_ok;
  logic [SCALE_W-1:0] scale;
  logic [CNT_W-1:0]   nbytes;

  assign fixed_ok = (word_i[29:27] == 3'b111) && word_i[26] &&
                    (word_i[25:24] == 2'b00) && !word_i[21] &&
                    (word_i[11:10] == 2'b00);
  assign scale    = {word_i[23], word_i[31:30]};

  always_comb begin
    dec_o.scale    = scale;
    dec_o.is_load  = word_i[22];
    dec_o.imm      = word_i[20:12];
    dec_o.base_idx = word_i[9:5];
    dec_o.xfer_idx = word_i[4:0];
    dec_o.use_sp   = (word_i[9:5] == '1);
    dec_o.undef    = !fixed_ok || (scale > SCALE_W'(MAX_SCALE));
  end

  assign nbytes = CNT_W'(1) << scale;

  always_comb begin
    for (int i = 0; i < BE_W; i++) begin
      be_o[i] = (CNT_W'(i) < nbytes);
    end
  end
endmodule

// File: rtl/vls_lane.sv
module vls_lane #(
  parameter int VEC_W = 128,
  localparam int BE_W = VEC_W / 8
) (
  input  logic [BE_W-1:0]  be_i,
  input  logic [VEC_W-1:0] data_i,
  output logic [VEC_W-1:0] data_o
);
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign data_o[b*8 +: 8] = be_i[b] ? data_i[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/vls_unit.sv
module vls_unit
  import vls_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VEC_W  = 128,
  parameter int ALIGN_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  instr_valid,
  output logic                  instr_ready,
  input  logic [INSTR_W-1:0]    instr_word,
  output logic [RIDX_W-1:0]     gpr_rd_idx,
  input  logic [ADDR_W-1:0]     gpr_rd_data,
  input  logic [ADDR_W-1:0]     sp_value,
  output logic [RIDX_W-1:0]     vreg_rd_idx,
  input  logic [VEC_W-1:0]      vreg_rd_data,
  output logic                  vreg_wr_en,
  output logic [RIDX_W-1:0]     vreg_wr_idx,
  output logic [VEC_W-1:0]      vreg_wr_data,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [ADDR_W-1:0]     req_addr,
  output logic                  req_write,
  output logic [SCALE_W-1:0]    req_size,
  output logic                  req_tagged,
  output logic [VEC_W/8-1:0]    req_be,
  output logic [VEC_W-1:0]      req_wdata,
  input  logic                  rsp_valid,
  output logic                  rsp_ready,
  input  logic [VEC_W-1:0]      rsp_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  undef_flag,
  output logic                  align_fault
);
  localparam int BE_W = VEC_W / 8;

  vls_dec_t          dec;
  logic [BE_W-1:0]   dec_be;
  logic [ADDR_W-1:0] base_val, eff_addr;
  logic [VEC_W-1:0]  store_data, load_data;
  logic              sp_bad;

  vls_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q, tag_q;
  logic [SCALE_W-1:0] scale_q;
  logic [BE_W-1:0]   be_q;
  logic [VEC_W-1:0]  wdata_q, wr_data_q;
  logic [RIDX_W-1:0] idx_q;
  logic              done_q, undef_q, fault_q, wr_en_q;

  vls_decode #(.BE_W(BE_W)) dec_i (
    .word_i (instr_word),
    .dec_o  (dec),
    .be_o   (dec_be)
  );

  vls_lane #(.VEC_W(VEC_W)) st_lane_i (
    .be_i   (dec_be),
    .data_i (vreg_rd_data),
    .data_o (store_data)
  );

  vls_lane #(.VEC_W(VEC_W)) ld_lane_i (
    .be_i   (be_q),
    .data_i (rsp_rdata),
    .data_o (load_data)
  );

  assign gpr_rd_idx  = dec.base_idx;
  assign vreg_rd_idx = dec.xfer_idx;
  assign base_val    = dec.use_sp ? sp_value : gpr_rd_data;
  assign eff_addr    = base_val + {{(ADDR_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
  assign sp_bad      = dec.use_sp && (sp_value[ALIGN_BITS-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      write_q   <= 1'b0;
      tag_q     <= 1'b0;
      scale_q   <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      wr_data_q <= '0;
      idx_q     <= '0;
      done_q    <= 1'b0;
      undef_q   <= 1'b0;
      fault_q   <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      wr_en_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (instr_valid) begin
            if (dec.undef) begin
              done_q  <= 1'b1;
              undef_q <= 1'b1;
            end else if (sp_bad) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              state_q <= ST_ACCESS;
              addr_q  <= eff_addr;
              write_q <= !dec.is_load;
              tag_q   <= !dec.use_sp;
              scale_q <= dec.scale;
              be_q    <= dec_be;
              wdata_q <= store_data;
              idx_q   <= dec.xfer_idx;
            end
          end
        end
        ST_ACCESS: begin
          if (req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (!write_q) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= load_data;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign instr_ready  = (state_q == ST_IDLE);
  assign busy         = (state_q != ST_IDLE);
  assign req_valid    = (state_q == ST_ACCESS);
  assign rsp_ready    = (state_q == ST_WAIT);
  assign req_addr     = addr_q;
  assign req_write    = write_q;
  assign req_size     = scale_q;
  assign req_tagged   = tag_q;
  assign req_be       = be_q;
  assign req_wdata    = wdata_q;
  assign vreg_wr_en   = wr_en_q;
  assign vreg_wr_idx  = idx_q;
  assign vreg_wr_data = wr_data_q;
  assign done         = done_q;
  assign undef_flag   = undef_q;
  assign align_fault  = fault_q;
endmodule

// File: rtl/vls_unit_chk.sv
module vls_unit_chk #(
  parameter int ADDR_W = 64,
  parameter int VEC_W  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_ready,
  input logic              busy,
  input logic              done,
  input logic              undef_flag,
  input logic              align_fault,
  input logic              vreg_wr_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic [2:0]        req_size,
  input logic [VEC_W/8-1:0] req_be,
  input logic              rsp_ready
);
  p_be_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size <= 3'd4) && req_be[0] &&
                  ($countones(req_be) == (32'd1 << req_size)));

  p_undef_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> done && !vreg_wr_en && !req_valid && !align_fault);

  p_fault_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> done && !vreg_wr_en && !req_valid);

  p_write_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vreg_wr_en |-> done && !busy);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) &&
                                  $stable(req_write) && $stable(req_size));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !instr_ready);

  p_rsp_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !req_valid);
endmodule

bind vls_unit vls_unit_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_ready (instr_ready),
  .busy        (busy),
  .done        (done),
  .undef_flag  (undef_flag),
  .align_fault (align_fault),
  .vreg_wr_en  (vreg_wr_en),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_write   (req_write),
  .req_size    (req_size),
  .req_be      (req_be),
  .rsp_ready   (rsp_ready)
);

// File: tb/vls_unit_tb.sv
module vls_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instr_valid = 1'b0;
  logic         instr_ready;
  logic [31:0]  instr_word = '0;
  logic [4:0]   gpr_rd_idx;
  logic [63:0]  gpr_rd_data;
  logic [63:0]  sp_value = '0;
  logic [4:0]   vreg_rd_idx;
  logic [127:0] vreg_rd_data;
  logic         vreg_wr_en;
  logic [4:0]   vreg_wr_idx;
  logic [127:0] vreg_wr_data;
  logic         req_valid;
  logic         req_ready = 1'b0;
  logic [63:0]  req_addr;
  logic         req_write;
  logic [2:0]   req_size;
  logic         req_tagged;
  logic [15:0]  req_be;
  logic [127:0] req_wdata;
  logic         rsp_valid = 1'b0;
  logic         rsp_ready;
  logic [127:0] rsp_rdata = '0;
  logic         busy, done, undef_flag, align_fault;

  int checks = 0;
  int errors = 0;
  bit exp_busy = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [63:0] gpr_fn(input logic [4:0] idx);
    return 64'h0000_4000_0000_0000 + {51'd0, idx, 8'h00};
  endfunction

  function automatic logic [127:0] vec_fn(input logic [4:0] idx);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[k*8 +: 8] = 8'(k * 17) ^ {3'b0, idx};
    return v;
  endfunction

  function automatic logic [127:0] keep_low(input logic [127:0] v, input int nbytes);
    logic [127:0] r = '0;
    for (int k = 0; k < nbytes; k++) r[k*8 +: 8] = v[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [1:0] opc,
                                     input logic [8:0] imm, input logic [4:0] rn,
                                     input logic [4:0] rt);
    return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm, 2'b00, rn, rt};
  endfunction

  assign gpr_rd_data  = gpr_fn(gpr_rd_idx);
  assign vreg_rd_data = vec_fn(vreg_rd_idx);

  vls_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .gpr_rd_idx(gpr_rd_idx), .gpr_rd_data(gpr_rd_data),
    .sp_value(sp_value), .vreg_rd_idx(vreg_rd_idx), .vreg_rd_data(vreg_rd_data),
    .vreg_wr_en(vreg_wr_en), .vreg_wr_idx(vreg_wr_idx), .vreg_wr_data(vreg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_tagged(req_tagged),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
    .undef_flag(undef_flag), .align_fault(align_fault)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every-clock comparison of the busy/ready model (R10)
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      chk("R10 busy", {127'd0, busy}, {127'd0, exp_busy});
      chk("R10 instr_ready", {127'd0, instr_ready}, {127'd0, !exp_busy});
    end
  end

  // Full access: returns after checking the done cycle
  task automatic run_access(input logic [31:0] w, input logic [63:0] base,
                            input int req_wait, input int rsp_wait,
                            input logic [127:0] mem_data);
    logic [2:0]  scale = {w[23], w[31:30]};
    int          nb = 1 << scale;
    logic        is_ld = w[22];
    logic [63:0] exp_addr = base + 64'($signed(w[20:12]));
    logic [15:0] exp_be = 16'((32'd1 << nb) - 1);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0; exp_busy = 1'b1;
    for (int i = 0; i < req_wait; i++) @(negedge clk);
    #1;
    chk("R10 req_valid", {127'd0, req_valid}, 128'd1);
    chk("R4 address", {64'd0, req_addr}, {64'd0, exp_addr});
    chk("R1 size", {125'd0, req_size}, {125'd0, scale});
    chk("R1 byte enables", {112'd0, req_be}, {112'd0, exp_be});
    chk("R5 direction", {127'd0, req_write}, {127'd0, !is_ld});
    chk("R6 tag flag", {127'd0, req_tagged}, {127'd0, (w[9:5] != 5'd31)});
    if (!is_ld) chk("R9 store data", req_wdata, keep_low(vec_fn(w[4:0]), nb));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    chk("R10 req dropped", {127'd0, req_valid}, 128'd0);
    for (int i = 0; i < rsp_wait; i++) @(negedge clk);
    rsp_valid = 1'b1; rsp_rdata = mem_data;
    @(negedge clk);
    rsp_valid = 1'b0; exp_busy = 1'b0;
    #1;
    chk("R10 done pulse", {127'd0, done}, 128'd1);
    chk("R8 write strobe", {127'd0, vreg_wr_en}, {127'd0, is_ld});
    if (is_ld) begin
      chk("R8 write index", {123'd0, vreg_wr_idx}, {123'd0, w[4:0]});
      chk("R8 zero-extended data", vreg_wr_data, keep_low(mem_data, nb));
    end
    @(negedge clk);
    #1;
    chk("R10 done one cycle", {127'd0, done}, 128'd0);
  endtask

  // Early-ending instruction: undefined or misaligned
  task automatic run_reject(input logic [31:0] w, input string req,
                            input bit exp_undef, input bit exp_fault);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = w;
    @(negedge clk);
    instr_valid = 1'b0;
    #1;
    chk({req, " done"}, {127'd0, done}, 128'd1);
    chk({req, " undef flag"}, {127'd0, undef_flag}, {127'd0, exp_undef});
    chk({req, " align fault"}, {127'd0, align_fault}, {127'd0, exp_fault});
    chk({req, " no request"}, {127'd0, req_valid}, 128'd0);
    chk({req, " no write"}, {127'd0, vreg_wr_en}, 128'd0);
    @(negedge clk);
    #1;
    chk({req, " still no request"}, {127'd0, req_valid}, 128'd0);
    chk({req, " done cleared"}, {127'd0, done}, 128'd0);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 reset busy", {127'd0, busy}, 128'd0);
    chk("R10 reset ready", {127'd0, instr_ready}, 128'd1);
    chk("R10 reset req", {127'd0, req_valid}, 128'd0);
    chk("R10 reset done", {127'd0, done}, 128'd0);

    // R1 R4 R8: byte load, positive offset, general register base
    run_access(mk(2'b00, 2'b01, 9'd255, 5'd5, 5'd3), gpr_fn(5'd5), 0, 0,
               128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    // R8: 128-bit load, most negative offset, wait states
    run_access(mk(2'b00, 2'b11, 9'h100, 5'd7, 5'd30), gpr_fn(5'd7), 3, 2,
               128'hdead_beef_cafe_f00d_1122_3344_5566_7788);
    // R8: half and double loads
    run_access(mk(2'b01, 2'b01, 9'h1f0, 5'd0, 5'd1), gpr_fn(5'd0), 1, 0,
               128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_a5a5);
    run_access(mk(2'b11, 2'b01, 9'd8, 5'd12, 5'd9), gpr_fn(5'd12), 0, 4,
               128'h1111_2222_3333_4444_5555_6666_7777_8888);
    // R9 R5: 32-bit and 128-bit stores
    run_access(mk(2'b10, 2'b00, 9'd4, 5'd2, 5'd17), gpr_fn(5'd2), 2, 1, '0);
    run_access(mk(2'b00, 2'b10, 9'h1ff, 5'd30, 5'd31), gpr_fn(5'd30), 0, 0, '0);
    // R6: stack-pointer base, aligned, with wrap below zero (R4)
    sp_value = 64'h0;
    run_access(mk(2'b01, 2'b01, 9'h1f0, 5'd31, 5'd4), 64'h0, 1, 1,
               128'h0000_0000_0000_0000_0000_0000_0000_beef);
    sp_value = 64'h0000_7fff_0000_1230;
    run_access(mk(2'b11, 2'b00, 9'd16, 5'd31, 5'd6), sp_value, 0, 0, '0);
    // R7: misaligned stack pointer
    sp_value = 64'h0000_7fff_0000_1238;
    run_reject(mk(2'b10, 2'b01, 9'd0, 5'd31, 5'd2), "R7", 1'b0, 1'b1);
    // R7 does not apply to a general register base
    run_access(mk(2'b10, 2'b01, 9'd1, 5'd9, 5'd2), gpr_fn(5'd9), 0, 0,
               128'h0000_0000_0000_0000_0000_0000_8765_4321);
    // R2: width codes 5, 6, 7
    run_reject(mk(2'b01, 2'b11, 9'd0, 5'd1, 5'd1), "R2 code5", 1'b1, 1'b0);
    run_reject(mk(2'b10, 2'b10, 9'd0, 5'd1, 5'd1), "R2 code6", 1'b1, 1'b0);
    run_reject(mk(2'b11, 2'b11, 9'd0, 5'd31, 5'd1), "R2 code7", 1'b1, 1'b0);
    // R3: fixed field mismatches
    run_reject(mk(2'b00, 2'b01, 9'd0, 5'd1, 5'd1) | 32'h0020_0000, "R3 bit21", 1'b1, 1'b0);
    run_reject(mk(2'b00, 2'b01, 9'd0, 5'd1, 5'd1) | 32'h0000_0400, "R3 bit10", 1'b1, 1'b0);
    run_reject(mk(2'b00, 2'b01, 9'd0, 5'd1, 5'd1) & ~32'h0400_0000, "R3 bit26", 1'b1, 1'b0);
    run_reject(mk(2'b00, 2'b01, 9'd0, 5'd1, 5'd1) & ~32'h1000_0000, "R3 bit28", 1'b1, 1'b0);
    run_reject(mk(2'b00, 2'b01, 9'd0, 5'd1, 5'd1) | 32'h0100_0000, "R3 bit24", 1'b1, 1'b0);
    // Normal access after rejections still works
    run_access(mk(2'b00, 2'b01, 9'd3, 5'd4, 5'd8), gpr_fn(5'd4), 0, 0,
               128'h0000_0000_0000_0000_0000_0000_0000_005a);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule